// File: doc/BRIEF.md
# Epoch-Stamped Hit Message Generator

This block sits in front-end readout logic. It takes hits from self-triggered channel logic and turns them into one stream of short messages. A free-running fine counter divides time into epochs of a fixed number of clock cycles. Each hit leaves the block carrying only its position inside the current epoch. An epoch marker message carries the coarse time, meaning the epoch number.

A marker is queued at the start of every epoch, whether or not any hit occurred, so the receiver also sees a steady heartbeat. Downstream logic rebuilds absolute time as epoch number times epoch length plus the fine stamp. It takes the epoch number from the latest marker it has seen.

Messages wait in a small queue that drains through a valid/ready interface. When the queue runs short of room, new hits are discarded and counted. One slot is always kept free for markers.

Top module: `epoch_hit_framer`

## Requirements
- R1: While `rst_n` is low, `msg_valid` and `hits_dropped` are 0. The first message after reset is a marker for epoch 0.
- R2: The fine counter counts 0 to EPOCH_LEN-1 and wraps. At each wrap the epoch number rises by one. A marker is queued in every cycle in which the fine count is 0, even when no hit arrives.
- R3: A hit message has `msg_is_marker`=0. Its `msg_data` holds four fields, from MSB to LSB: chip id (CHIP_W bits), channel (CHAN_W bits), time stamp (FINE_W+SUB_W bits), and amplitude (AMP_W bits, the LSBs).
- R4: A marker message has `msg_is_marker`=1. Its `msg_data` holds the chip id in the top CHIP_W bits and the epoch number in the low EPOCH_W bits. All bits in between are zero.
- R5: The time stamp is the fine count in the cycle the hit was presented, concatenated above `hit_sub`. Hence (epoch × EPOCH_LEN + fine) × 2^SUB_W + sub equals the hit's injection time.
- R6: A hit presented in a cycle where the fine count is 0 is stamped with fine 0. It is queued directly behind the marker of that same epoch.
- R7: Messages leave in the order they were queued. Every hit follows the marker of its own epoch.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_data` and `msg_is_marker` hold their values.
- R9: A hit is accepted only if the queue occupancy, plus one if a marker is queued in the same cycle, is at most FIFO_DEPTH-2. Otherwise the hit is dropped and `hits_dropped` rises by one, saturating at its maximum value.
- R10: A marker is never dropped, provided the sink takes at least one message per epoch.
- R11: The chip id is captured from `cfg_chip_id` while reset is asserted. Later changes to `cfg_chip_id` do not alter any message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chip_id | input | CHIP_W | Chip identifier, sampled during reset |
| hit_valid | input | 1 | A channel hit is present this cycle |
| hit_chan | input | CHAN_W | Channel of the hit |
| hit_amp | input | AMP_W | Amplitude of the hit |
| hit_sub | input | max(SUB_W,1) | Discriminator time within the clock cycle |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Sink accepts the offered message |
| msg_data | output | MSG_W | Message payload |
| msg_is_marker | output | 1 | 1 for an epoch marker, 0 for a hit |
| hits_dropped | output | DROP_W | Saturating count of discarded hits |

## Verification
The bench injects a hit in the boundary cycle of an epoch and one in the last cycle before it. A design that checked the rollover late would stamp the first hit with the old epoch, or let it overtake the marker. Time would then be rebuilt one full epoch off.

The bench holds off the sink long enough to fill the queue and to place an epoch boundary inside the stall. A design without the reserved slot would either lose that marker or write over a queued entry. An off-by-one in the admission rule would show as a wrong drop count.

The bench changes the chip id after reset. A design that reads it live would stamp later messages with the new value.

// File: rtl/ehf_pkg.sv
package ehf_pkg;
   typedef enum logic {
      KIND_HIT  = 1'b0,
      KIND_MARK = 1'b1
   } msg_kind_e;
endpackage

// File: rtl/ehf_epoch_timer.sv
module ehf_epoch_timer #(
   parameter int EPOCH_LEN = 1250,
   parameter int EPOCH_W   = 24,
   localparam int FINE_W   = $clog2(EPOCH_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [FINE_W-1:0]  fine,
   output logic [EPOCH_W-1:0] epoch,
   output logic               boundary
);
   localparam logic [FINE_W-1:0] LAST = FINE_W'(EPOCH_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fine  <= '0;
         epoch <= '0;
      end else if (fine == LAST) begin
         fine  <= '0;
         epoch <= epoch + 1'b1;
      end else begin
         fine  <= fine + 1'b1;
      end
   end

   assign boundary = (fine == '0);

   // R2: fine count stays inside the epoch
   p_fine_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fine) < EPOCH_LEN);
   // R2: the wrap advances the epoch by exactly one
   p_epoch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fine == LAST) |=> (fine == '0) && (epoch == $past(epoch) + 1'b1));
   // R2: the epoch holds between wraps
   p_epoch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fine != LAST) |=> $stable(epoch));
endmodule

// File: rtl/ehf_dual_fifo.sv
module ehf_dual_fifo #(
   parameter int W     = 41,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_a,
   input  logic [W-1:0]  din_a,
   input  logic          push_b,
   input  logic [W-1:0]  din_b,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [AW:0]   count,
   output logic          not_empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd, wr, wr_b;
   logic          pop_ok;

   assign wr_b      = wr + AW'(push_a);
   assign not_empty = (count != '0);
   assign pop_ok    = pop && not_empty;
   assign dout      = mem[rd];

   always_ff @(posedge clk) begin
      if (rst_n && push_a) mem[wr]   <= din_a;
      if (rst_n && push_b) mem[wr_b] <= din_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd    <= '0;
         wr    <= '0;
         count <= '0;
      end else begin
         wr    <= wr + AW'(push_a) + AW'(push_b);
         rd    <= rd + AW'(pop_ok);
         count <= count + (AW+1)'(push_a) + (AW+1)'(push_b) - (AW+1)'(pop_ok);
      end
   end

   // R10: occupancy never exceeds the storage
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);
   // R8: an offered entry is held while the sink stalls
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (not_empty && !pop) |=> not_empty && $stable(dout));
endmodule

// File: rtl/epoch_hit_framer.sv
module epoch_hit_framer
   import ehf_pkg::*;
#(
   parameter int CHIP_W     = 10,
   parameter int CHAN_W     = 6,
   parameter int AMP_W      = 10,
   parameter int SUB_W      = 3,
   parameter int EPOCH_LEN  = 1250,
   parameter int EPOCH_W    = 24,
   parameter int FIFO_DEPTH = 4,
   parameter int DROP_W     = 16,
   localparam int FINE_W    = $clog2(EPOCH_LEN),
   localparam int SUB_PW    = (SUB_W > 0) ? SUB_W : 1,
   localparam int STAMP_W   = FINE_W + SUB_W,
   localparam int MSG_W     = CHIP_W + CHAN_W + STAMP_W + AMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHIP_W-1:0] cfg_chip_id,
   input  logic              hit_valid,
   input  logic [CHAN_W-1:0] hit_chan,
   input  logic [AMP_W-1:0]  hit_amp,
   input  logic [SUB_PW-1:0] hit_sub,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [MSG_W-1:0]  msg_data,
   output logic              msg_is_marker,
   output logic [DROP_W-1:0] hits_dropped
);
   localparam int QW = MSG_W + 1;
   localparam int AW = $clog2(FIFO_DEPTH);

   // elaboration-time parameter checks
   if (EPOCH_LEN < 2 || EPOCH_LEN <= FIFO_DEPTH)
      $error("EPOCH_LEN must exceed FIFO_DEPTH and be at least 2");
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
      $error("FIFO_DEPTH must be a power of two, at least 2");
   if (CHIP_W + EPOCH_W > MSG_W)
      $error("marker fields do not fit the message width");
   if (MSG_W > 80)
      $error("message exceeds ten bytes");
   if (SUB_W < 0 || DROP_W < 1)
      $error("bad SUB_W or DROP_W");

   logic [CHIP_W-1:0]  chip_q;
   logic [FINE_W-1:0]  fine;
   logic [EPOCH_W-1:0] epoch;
   logic               boundary;
   logic [STAMP_W-1:0] stamp;
   logic [MSG_W-1:0]   hit_word, mark_word;
   logic [AW:0]        occ;
   logic               hit_ok;
   logic [QW-1:0]      head;
   logic [DROP_W-1:0]  drop_q;

   // R11: chip id captured only while in reset
   always_ff @(posedge clk) begin
      if (!rst_n) chip_q <= cfg_chip_id;
   end

   ehf_epoch_timer #(.EPOCH_LEN(EPOCH_LEN), .EPOCH_W(EPOCH_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .fine(fine), .epoch(epoch), .boundary(boundary)
   );

   // time stamp variant: with or without sub-cycle bits
   if (SUB_W > 0) begin : g_stamp_sub
      assign stamp = {fine, hit_sub};
   end else begin : g_stamp_plain
      logic unused_sub;
      assign unused_sub = ^hit_sub;
      assign stamp = fine;
   end

   assign hit_word = {chip_q, hit_chan, stamp, hit_amp};

   always_comb begin
      mark_word = '0;
      mark_word[MSG_W-1 -: CHIP_W] = chip_q;
      mark_word[EPOCH_W-1:0]       = epoch;
   end

   // R9: keep one slot free for markers
   assign hit_ok = hit_valid && ((int'(occ) + int'(boundary)) <= FIFO_DEPTH - 2);

   ehf_dual_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push_a(boundary), .din_a({KIND_MARK, mark_word}),
      .push_b(hit_ok),   .din_b({KIND_HIT, hit_word}),
      .pop(msg_ready), .dout(head), .count(occ), .not_empty(msg_valid)
   );

   assign msg_is_marker = head[QW-1];
   assign msg_data      = head[MSG_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         drop_q <= '0;
      else if (hit_valid && !hit_ok && drop_q != '1)
         drop_q <= drop_q + 1'b1;
   end
   assign hits_dropped = drop_q;

   // R10: a boundary always finds a free slot
   p_marker_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |-> int'(occ) < FIFO_DEPTH);
   // R9: an accepted hit never takes the reserved slot
   p_reserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ok |=> int'(occ) < FIFO_DEPTH);
   // R9: each refused hit is counted once
   p_drop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_ok && hits_dropped != '1) |=> hits_dropped == $past(hits_dropped) + 1'b1);
   // R11: captured chip id holds after reset
   p_chip_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(chip_q));
endmodule

// File: tb/test_epoch_hit_framer.sv
module test_epoch_hit_framer;
   localparam int CHIP_W = 10, CHAN_W = 6, AMP_W = 10, SUB_W = 3;
   localparam int EPOCH_LEN = 40, EPOCH_W = 24, DEPTH = 4, DROP_W = 16;
   localparam int FINE_W = $clog2(EPOCH_LEN);
   localparam int MSG_W = CHIP_W + CHAN_W + FINE_W + SUB_W + AMP_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CHIP_W-1:0] cfg_chip_id = 10'h2A5;
   logic hit_valid = 1'b0;
   logic [CHAN_W-1:0] hit_chan = '0;
   logic [AMP_W-1:0] hit_amp = '0;
   logic [SUB_W-1:0] hit_sub = '0;
   logic msg_valid, msg_ready = 1'b0, msg_is_marker;
   logic [MSG_W-1:0] msg_data;
   logic [DROP_W-1:0] hits_dropped;

   always #4 clk = ~clk;

   epoch_hit_framer #(.CHIP_W(CHIP_W), .CHAN_W(CHAN_W), .AMP_W(AMP_W), .SUB_W(SUB_W),
      .EPOCH_LEN(EPOCH_LEN), .EPOCH_W(EPOCH_W), .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)) i_epoch_hit_framer (
      .clk(clk), .rst_n(rst_n), .cfg_chip_id(cfg_chip_id), .hit_valid(hit_valid),
      .hit_chan(hit_chan), .hit_amp(hit_amp), .hit_sub(hit_sub), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_data(msg_data), .msg_is_marker(msg_is_marker),
      .hits_dropped(hits_dropped));

   int checks = 0, fails = 0;
   int n = 0, exp_drop = 0;
   logic [CHIP_W-1:0] chip_ref = 10'h2A5;
   logic [MSG_W:0] exp_q[$];
   longint abs_q[$];
   longint last_epoch = -1;
   logic prev_hold = 1'b0;
   logic [MSG_W:0] prev_word = '0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h (n=%0d)", req, act, expv, n);
      end
   endtask

   function automatic logic [MSG_W:0] mk_hit(int chan, int fine, int sub, int amp);
      return {1'b0, chip_ref, CHAN_W'(chan), FINE_W'(fine), SUB_W'(sub), AMP_W'(amp)};
   endfunction

   function automatic logic [MSG_W:0] mk_mark(int ep);
      logic [MSG_W:0] w;
      w = '0;
      w[MSG_W] = 1'b1;
      w[MSG_W-1 -: CHIP_W] = chip_ref;
      w[EPOCH_W-1:0] = EPOCH_W'(ep);
      return w;
   endfunction

   // called at a negedge: observe, drive, model the coming edge, wait a cycle
   task automatic step(input bit rdy, input bit hv, input int chan, input int amp, input int sub);
      logic [MSG_W:0] word;
      int occ, fine;
      bit mk, acc;
      word = {msg_is_marker, msg_data};
      check(msg_valid == (exp_q.size() != 0), "R7 valid", longint'(msg_valid), longint'(exp_q.size() != 0));
      if (msg_valid && exp_q.size() != 0) begin
         if (exp_q[0][MSG_W])
            check(word == exp_q[0], "R2 R4 R10 R11 marker", 64'(word), 64'(exp_q[0]));
         else if (exp_q[0][AMP_W+SUB_W +: FINE_W] == '0)
            check(word == exp_q[0], "R6 R3 hit", 64'(word), 64'(exp_q[0]));
         else
            check(word == exp_q[0], "R3 R7 R11 hit", 64'(word), 64'(exp_q[0]));
      end
      if (prev_hold)
         check(msg_valid && word == prev_word, "R8 hold", 64'(word), 64'(prev_word));
      check(int'(hits_dropped) == exp_drop, "R9 drop count", longint'(hits_dropped), longint'(exp_drop));
      if (n == 1)
         check(msg_is_marker && msg_data[EPOCH_W-1:0] == '0, "R1 first marker", 64'(word), 64'(mk_mark(0)));
      prev_hold = msg_valid && !rdy;
      prev_word = word;
      msg_ready = rdy;
      hit_valid = hv;
      hit_chan = CHAN_W'(chan);
      hit_amp = AMP_W'(amp);
      hit_sub = SUB_W'(sub);
      occ = exp_q.size();
      fine = n % EPOCH_LEN;
      mk = (fine == 0);
      acc = hv && (occ + int'(mk) <= DEPTH - 2);
      if (rdy && occ > 0) begin
         if (exp_q[0][MSG_W]) begin
            last_epoch = longint'(exp_q[0][EPOCH_W-1:0]);
         end else begin
            longint rebuilt;
            rebuilt = ((last_epoch * EPOCH_LEN + longint'(exp_q[0][AMP_W+SUB_W +: FINE_W])) << SUB_W)
                      + longint'(exp_q[0][AMP_W +: SUB_W]);
            check(rebuilt == abs_q[0], "R5 rebuilt time", rebuilt, abs_q[0]);
         end
         void'(exp_q.pop_front());
         void'(abs_q.pop_front());
      end
      if (mk) begin
         exp_q.push_back(mk_mark(n / EPOCH_LEN));
         abs_q.push_back(-1);
      end
      if (acc) begin
         exp_q.push_back(mk_hit(chan, fine, sub, amp));
         abs_q.push_back((longint'(n) << SUB_W) + longint'(sub));
      end else if (hv) begin
         exp_drop++;
      end
      n++;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(msg_valid == 1'b0, "R1 valid in reset", longint'(msg_valid), 0);
      check(hits_dropped == '0, "R1 drops in reset", longint'(hits_dropped), 0);
      rst_n = 1'b1;
      // R2 heartbeat: two epochs with no hits
      while (n < 2 * EPOCH_LEN - 1) step(1'b1, 1'b0, 0, 0, 0);
      // last fine cycle, then boundary cycle (R6)
      step(1'b1, 1'b1, 5, 300, 7);
      step(1'b1, 1'b1, 9, 17, 2);
      while (n < 3 * EPOCH_LEN - 10) step(1'b1, 1'b0, 0, 0, 0);
      // R9/R10: stall across an epoch boundary with a hit every cycle
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, i, 100 + i, i % 8);
      // R11: chip id change after reset must not show up
      cfg_chip_id = 10'h15A;
      for (int i = 0; i < 2500; i++)
         step(($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % 64),
              int'($urandom % 1024), int'($urandom % 8));
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 0, 0, 0);
      check(exp_drop > 0, "R9 drops exercised", longint'(exp_drop), 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=%0d exp=done", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule